// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a processor bus and the byte-stream side of a simple serial port. Software sees a small word-addressed register window with three registers: one to send a byte, one to collect a received byte, and a status word with two flags. The line side has one byte-wide transmit stream and one byte-wide receive stream, and each uses a valid/ready handshake. The shift logic, the baud timing and any queueing all sit outside this block.

The block holds one received byte. Once that byte is captured, the receive stream is stalled until software reads the byte out. A written transmit byte waits in a one-entry holding slot until the line side takes it. While that byte waits, the transmit-ready flag is low and further transmit writes are dropped. Accesses to offsets that are not defined, partial-word accesses and misaligned accesses read as zero and change nothing.

Top module: `sport_regfront`

## Requirements
- R1: After reset the receive holding byte is zero, `rx_ready` is high, `tx_valid` is low and the status register reads 0x0000_0002.
- R2: The status register sits at byte offset 0x14. Bit 0 is the receive-ready flag (a byte is held) and bit 1 is the transmit-ready flag (the transmit slot is empty). Bits 31..2 read as zero.
- R3: When `rx_valid` and `rx_ready` are both high at a clock edge, the block stores `rx_data`, sets the receive-ready flag and drives `rx_ready` low from the next cycle.
- R4: A read of the receive data register at offset 0x04 returns the held byte in bits 7..0, with zeros above. The same access clears the receive-ready flag, so `rx_ready` is high again in the following cycle.
- R5: While the receive-ready flag is set, `rx_ready` stays low and the held byte is not overwritten by any byte offered on the receive stream.
- R6: A write to the transmit data register at offset 0x00 while the slot is empty presents bits 7..0 of the written word on `tx_data`, with `tx_valid` high from the next cycle. Both are held until a cycle in which `tx_ready` is high.
- R7: While a transmit byte is pending, status bit 1 reads 0, and a write to the transmit data register is discarded.
- R8: Writes to the status register have no effect on any state.
- R9: Reads of the undefined word offsets (0x08, 0x0C, 0x10, 0x18, 0x1C) return zero, and writes to them have no effect.
- R10: Only aligned full-word accesses take effect. An access with `bus_be` other than 4'hF, or with `bus_addr[1:0]` nonzero, reads as zero and changes no state.
- R11: Every read request sets `bus_rvalid` high for exactly the following cycle, with the read value on `bus_rdata` in that cycle. Writes never raise `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address within the register window |
| bus_be | input | BUS_W/8 (4) | Byte enables; all must be set for a valid access |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Line side takes the transmit byte |
| tx_data | output | DATA_W (8) | Transmit byte |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_ready | output | 1 | Block can take a received byte |
| rx_data | input | DATA_W (8) | Received byte |

## Verification
Every result of this block appears exactly one clock edge after its cause. Read data and `bus_rvalid` appear the cycle after the request. `tx_valid` rises the cycle after a transmit write and falls the cycle after the handshake. `rx_ready` falls the cycle after a capture and rises the cycle after a receive-data read. The bench drives every input on the falling edge, lets one rising edge act, and samples on the next falling edge, so each check sees the state one register stage after the stimulus. A status read returns the flags as they stood before that read's own edge, and the expected values are computed the same way.

// File: rtl/sport_pkg.sv
// Shared constants for the serial port register front end.
// Assumes a word-addressed window where the word index is addr >> 2.
package sport_pkg;
    // Word indices of the defined registers
    localparam int IDX_TXD  = 0;
    localparam int IDX_RXD  = 1;
    localparam int IDX_STAT = 5;

    // Bit positions inside the status word
    localparam int ST_RXRDY = 0;
    localparam int ST_TXRDY = 1;

    // Decoded access kind
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_TX_WR,
        ACC_RX_RD,
        ACC_ST_RD,
        ACC_OTHER
    } acc_kind_t;
endpackage

// File: rtl/sport_bus_decode.sv
// Bus access decoder: classifies one request into a register action.
// Assumes one request per cycle. An access counts only when it is
// full-word and aligned. Undefined indices and status writes map to
// ACC_OTHER, which has no effect.
module sport_bus_decode #(
    parameter int ADDR_W = 5,
    parameter int BE_W   = 4
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    output sport_pkg::acc_kind_t kind,
    output logic              rd_any
);
    import sport_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic             word_ok;
    logic [IDX_W-1:0] idx;

    assign word_ok = (&bus_be) && (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[ADDR_W-1:2];
    assign rd_any  = bus_req && !bus_we;

    // Map the request to one action; anything invalid is ignored
    always_comb begin
        kind = ACC_NONE;
        if (bus_req) begin
            kind = ACC_OTHER;
            if (word_ok) begin
                if (bus_we && int'(idx) == IDX_TXD)
                    kind = ACC_TX_WR;
                else if (!bus_we && int'(idx) == IDX_RXD)
                    kind = ACC_RX_RD;
                else if (!bus_we && int'(idx) == IDX_STAT)
                    kind = ACC_ST_RD;
            end
        end
    end
endmodule

// File: rtl/sport_rx_hold.sv
// Receive holding register: keeps one byte and a full flag.
// Assumes the line side transfers only when valid and ready are both
// high. A capture wins over a clear in the same cycle, which can only
// happen while the register is empty.
module sport_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              rd_clear,
    output logic              full,
    output logic [DATA_W-1:0] hold
);
    logic take;

    assign rx_ready = !full;
    assign take     = rx_valid && rx_ready;

    // Capture an offered byte while empty; the holding read empties it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            hold <= '0;
        end else if (take) begin
            full <= 1'b1;
            hold <= rx_data;
        end else if (rd_clear) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/sport_tx_hold.sv
// Transmit holding slot: one pending byte offered on a valid/ready stream.
// Assumes a load arriving while a byte is pending is to be dropped,
// including in the cycle in which the pending byte is taken.
module sport_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              pend
);
    assign tx_valid = pend;

    // Accept a load only into an empty slot; drop pending on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            tx_data <= '0;
        end else if (pend) begin
            if (tx_ready)
                pend <= 1'b0;
        end else if (load) begin
            pend    <= 1'b1;
            tx_data <= load_data;
        end
    end
endmodule

// File: rtl/sport_regfront.sv
// Serial port register front end (top).
// Holds a word-addressed window of transmit data, receive data and
// status. Read data is registered and is valid one cycle after the
// request. Assumes the bus issues at most one access per cycle.
module sport_regfront #(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W/8-1:0]  bus_be,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                bus_rvalid,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [DATA_W-1:0]   tx_data,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [DATA_W-1:0]   rx_data
);
    import sport_pkg::*;

    localparam int BE_W = BUS_W / 8;

    acc_kind_t         kind;
    logic              rd_any;
    logic              rd_rx;
    logic              rd_st;
    logic              wr_tx;
    logic              rx_full;
    logic [DATA_W-1:0] rx_hold;
    logic              tx_pend;
    logic [BUS_W-1:0]  stat_word;
    logic [BUS_W-1:0]  rd_mux;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:DATA_W];

    sport_bus_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .bus_req (bus_req),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .kind    (kind),
        .rd_any  (rd_any)
    );

    assign rd_rx = (kind == ACC_RX_RD);
    assign rd_st = (kind == ACC_ST_RD);
    assign wr_tx = (kind == ACC_TX_WR);

    sport_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_ready(rx_ready),
        .rd_clear(rd_rx),
        .full    (rx_full),
        .hold    (rx_hold)
    );

    sport_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_tx),
        .load_data(bus_wdata[DATA_W-1:0]),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .pend     (tx_pend)
    );

    // Assemble the status word from the two flags
    always_comb begin
        stat_word           = '0;
        stat_word[ST_RXRDY] = rx_full;
        stat_word[ST_TXRDY] = !tx_pend;
    end

    // Select read data; every other access reads as zero
    always_comb begin
        rd_mux = '0;
        if (rd_rx)
            rd_mux = {{(BUS_W-DATA_W){1'b0}}, rx_hold};
        else if (rd_st)
            rd_mux = stat_word;
    end

    // Register read data and its valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_any;
            if (rd_any)
                bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/sport_regfront_chk.sv
// Property checker for sport_regfront, attached by bind.
// Assumes the same parameters as the instance it is bound to.
module sport_regfront_chk #(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_any,
    input logic              rd_rx,
    input logic              rd_st,
    input logic              bus_rvalid,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_hold,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data
);
    // R3
    rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> !rx_ready);

    // R5
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> $stable(rx_hold));

    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx && !(rx_valid && rx_ready) |=> rx_ready);

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R11
    rvalid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> bus_rvalid);

    // R11
    rvalid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !bus_rvalid);

    // R2
    stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> bus_rdata[BUS_W-1:2] == '0);
endmodule

bind sport_regfront sport_regfront_chk #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_any    (rd_any),
    .rd_rx     (rd_rx),
    .rd_st     (rd_st),
    .bus_rvalid(bus_rvalid),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_hold   (rx_hold),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data)
);

// File: tb/sim_sport_regfront.sv
// Directed bench for sport_regfront: one task per scenario.
module sim_sport_regfront;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_TXD  = 5'h00;
    localparam logic [4:0] A_RXD  = 5'h04;
    localparam logic [4:0] A_STAT = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sport_regfront u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus write; returns at the falling edge after the acting edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R11 no rvalid on write", {31'b0, bus_rvalid}, 32'd0);
    endtask

    // One bus read; data sampled the cycle after the request
    task automatic rd(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R11 rvalid after read", {31'b0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    // Offer one byte on the receive stream for one cycle
    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        rd(A_STAT, 4'hF, d); chk("R1 status", d, 32'h2);
        rd(A_RXD, 4'hF, d);  chk("R1 rx hold zero", d, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        rx_push(8'hA5);
        chk("R3 rx_ready low", {31'b0, rx_ready}, 32'd0);
        rd(A_STAT, 4'hF, d); chk("R2 R3 status both", d, 32'h3);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h3C;
        repeat (3) begin
            @(negedge clk);
            chk("R5 stalled", {31'b0, rx_ready}, 32'd0);
        end
        rx_valid = 1'b0;
        rd(A_RXD, 4'hF, d);  chk("R4 R5 held byte", d, 32'hA5);
        chk("R4 rx_ready back", {31'b0, rx_ready}, 32'd1);
        rd(A_STAT, 4'hF, d); chk("R4 flag cleared", d, 32'h2);
        rx_push(8'h3C);
        rd(A_RXD, 4'hF, d);  chk("R4 second byte", d, 32'h3C);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        tx_ready = 1'b0;
        wr(A_TXD, 32'h1234_56C7, 4'hF);
        chk("R6 tx_valid", {31'b0, tx_valid}, 32'd1);
        chk("R6 tx_data", {24'b0, tx_data}, 32'hC7);
        rd(A_STAT, 4'hF, d); chk("R7 tx flag low", d, 32'h0);
        wr(A_TXD, 32'h99, 4'hF);
        chk("R7 write dropped", {24'b0, tx_data}, 32'hC7);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk);
        chk("R6 taken", {31'b0, tx_valid}, 32'd0);
        rd(A_STAT, 4'hF, d); chk("R7 tx flag back", d, 32'h2);
        wr(A_TXD, 32'hFFFF_FF5A, 4'hF);
        chk("R6 byte two", {24'b0, tx_data}, 32'h5A);
        @(negedge clk);
        chk("R6 one cycle", {31'b0, tx_valid}, 32'd0);
        tx_ready = 1'b0;
    endtask

    task automatic t_stat_wr();
        logic [31:0] d;
        rx_push(8'h11);
        wr(A_STAT, 32'h0, 4'hF);
        wr(A_STAT, 32'hFFFF_FFFF, 4'hF);
        chk("R8 tx untouched", {31'b0, tx_valid}, 32'd0);
        chk("R8 rx_ready", {31'b0, rx_ready}, 32'd0);
        rd(A_STAT, 4'hF, d); chk("R8 status", d, 32'h3);
    endtask

    task automatic t_undef();
        logic [31:0] d;
        logic [4:0] offs [5] = '{5'h08, 5'h0C, 5'h10, 5'h18, 5'h1C};
        foreach (offs[i]) begin
            rd(offs[i], 4'hF, d); chk("R9 undefined read", d, 32'h0);
            wr(offs[i], 32'hFFFF_FFFF, 4'hF);
            chk("R9 no tx", {31'b0, tx_valid}, 32'd0);
        end
        rd(A_STAT, 4'hF, d); chk("R9 status kept", d, 32'h3);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        wr(A_TXD, 32'h77, 4'h1);
        chk("R10 partial tx write", {31'b0, tx_valid}, 32'd0);
        wr(5'h01, 32'h77, 4'hF);
        chk("R10 misaligned tx write", {31'b0, tx_valid}, 32'd0);
        rd(A_RXD, 4'h3, d); chk("R10 partial read zero", d, 32'h0);
        rd(5'h05, 4'hF, d); chk("R10 misaligned read zero", d, 32'h0);
        chk("R10 flag kept", {31'b0, rx_ready}, 32'd0);
        rd(A_RXD, 4'hF, d); chk("R10 byte intact", d, 32'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx();
        t_tx();
        t_stat_wr();
        t_undef();
        t_partial();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule